// File: doc/BRIEF.md
# Two-Wire Register Access Decoder

This block is the transaction layer of a two-wire bus slave. A bit-level front end, outside this block, reports bus start and stop conditions, hands over each received byte and asks for the next byte to send during a read. The decoder interprets the first byte after every start as a control byte, owns the register pointer, and routes data bytes into one of two register spaces. It answers every received byte with an acknowledge decision and every read-byte request with a data byte.

There are two register spaces, selected by the device-type field of the control byte. The configuration space is a 32-byte bank that takes exactly one data byte per write transaction. The converter space holds eight 10-bit limit values, each split across two byte addresses, and supports page-mode writes and reads in which the pointer advances and wraps inside the limit block. A read is done as a random read: a write transaction sets the pointer, then a repeated start with the read bit returns data from it. The limit values are presented in parallel to the comparison logic that sits elsewhere.

States of the transaction machine: ST_IDLE (bus ignored until a start), ST_CTRL (expecting the control byte), ST_ADDR (expecting the pointer byte), ST_WDATA (accepting data bytes), ST_WDONE (configuration byte already taken, further bytes acknowledged and dropped), ST_RDATA (serving read requests). Transitions: a stop moves any state to ST_IDLE; a start moves any state to ST_CTRL; in ST_CTRL a matching control byte moves to ST_ADDR (write bit 0) or ST_RDATA (read bit 1), and any other control byte moves to ST_IDLE; ST_ADDR moves to ST_WDATA on its byte; ST_WDATA moves to ST_WDONE after one byte in the configuration space and stays put in the converter space.

Top module: `twi_reg_decoder`

## Requirements
- R1: The control byte is decoded as bits 7..4 device type, bits 3..1 bus address, bit 0 direction (1 = read). It is acknowledged only when the bus address equals `strap_addr` and the type is 4'b1011 (configuration space) or 4'b1001 (converter space); otherwise it and every further byte until the next start get `ack_ok` = 0.
- R2: Every cycle with `rx_valid` high produces `ack_valid` high on the next cycle, and every cycle with `tx_req` high produces `tx_valid` high on the next cycle, with `ack_ok` and `tx_byte` valid in that same cycle.
- R3: In a write transaction the first byte after the control byte loads the register pointer and is acknowledged.
- R4: In the configuration space, addresses 0x80..0x9F are stored; only the first data byte of a write transaction is applied, later data bytes are acknowledged and discarded, and the pointer does not move.
- R5: In the converter space the limit block is 0xF0..0xFF; limit k uses addresses 0xF0+2k (data bits 1..0 give limit bits 9..8, bits 7..2 ignored) and 0xF1+2k (limit bits 7..0), and appears on `lim_flat[10k+9:10k]`.
- R6: Each data byte written inside the limit block advances the pointer by one, wrapping from 0xFF to 0xF0.
- R7: In a read transaction each `tx_req` returns the byte at the pointer: a configuration byte keeps the pointer still, a limit byte advances it with the same wrap as R6, and a high limit byte reads back as six zero bits above limit bits 9..8.
- R8: A data byte written to an address outside the implemented range of the selected space is acknowledged, discarded and leaves the pointer unchanged; a read from such an address returns 0x00.
- R9: A stop returns the machine to ST_IDLE without changing the pointer, so a later read transaction with no pointer byte reads from where the last transaction left off.
- R10: A `tx_req` outside ST_RDATA, and a byte received in ST_RDATA, are served without effect: the first returns 0xFF, the second gets `ack_ok` = 0.
- R11: After reset the configuration bank, all limits and the pointer are zero, the machine is in ST_IDLE, `ack_valid` and `tx_valid` are low and `tx_byte` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Strapped bus address of this device |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end asks for the next byte to send |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid | output | 1 | `tx_byte` answers a request |
| tx_byte | output | 8 | Byte to send |
| lim_flat | output | 80 | Eight 10-bit limit values, limit k at bits 10k+9..10k |

## Verification
The bench aims at the pointer wrap from 0xFF to 0xF0, where a design that ran past the block would land a write in unimplemented space and the next read would return 0x00 instead of the wrapped limit. It writes a second configuration byte in one transaction, which a design without the single-byte rule would store over the neighbouring register. It sends control bytes with a wrong bus address and a wrong device type followed by more bytes, catching a design that acknowledges them or resumes decoding mid-transaction, and it reads after a stop with no pointer byte, which exposes a pointer that resets on stop. Out-of-range and cross-space accesses check that discarded writes leave the limits and pointer alone and that such reads give zero.

// File: rtl/twi_dec_pkg.sv
package twi_dec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_WDONE,
        ST_RDATA
    } dec_state_e;

    localparam logic [3:0] DT_CFG = 4'b1011;
    localparam logic [3:0] DT_ADC = 4'b1001;

endpackage

// File: rtl/twi_cfg_bank.sv
module twi_cfg_bank #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/twi_lim_bank.sv
module twi_lim_bank #(
    parameter int COUNT = 8,
    parameter int BITS  = 10,
    localparam int SW   = $clog2(COUNT),
    localparam int HI_W = BITS - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SW-1:0]     sel,
    input  logic              low_byte,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [COUNT*BITS-1:0] lim_flat
);

    logic [BITS-1:0] lim_arr [COUNT];

    for (genvar k = 0; k < COUNT; k++) begin : g_lim
        logic [BITS-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (we && sel == SW'(k)) begin
                if (low_byte) val_q[7:0]      <= wdata;
                else          val_q[BITS-1:8] <= wdata[HI_W-1:0];
            end
        end
        assign lim_arr[k]                = val_q;
        assign lim_flat[k*BITS +: BITS]  = val_q;
    end

    assign rdata = low_byte ? lim_arr[sel][7:0]
                            : {{(8-HI_W){1'b0}}, lim_arr[sel][BITS-1:8]};

endmodule

// File: rtl/twi_reg_decoder.sv
module twi_reg_decoder
    import twi_dec_pkg::*;
#(
    parameter int CFG_BASE  = 8'h80,
    parameter int CFG_DEPTH = 32,
    parameter int LIM_BASE  = 8'hF0,
    parameter int LIM_COUNT = 8,
    parameter int LIM_BITS  = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  strap_addr,
    input  logic                        bus_start,
    input  logic                        bus_stop,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    input  logic                        tx_req,
    output logic                        ack_valid,
    output logic                        ack_ok,
    output logic                        tx_valid,
    output logic [7:0]                  tx_byte,
    output logic [LIM_COUNT*LIM_BITS-1:0] lim_flat
);

    localparam int PTR_W    = 8;
    localparam int CFG_AW   = $clog2(CFG_DEPTH);
    localparam int LIM_SPAN = 2 * LIM_COUNT;
    localparam int LIM_IW   = $clog2(LIM_SPAN);
    localparam logic [PTR_W-1:0] CFG_LO = PTR_W'(CFG_BASE);
    localparam logic [PTR_W-1:0] LIM_LO = PTR_W'(LIM_BASE);

    dec_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             cfg_sel_q, cfg_sel_d;

    logic [PTR_W-1:0] cfg_off, lim_off, lim_next;
    logic [LIM_IW-1:0] lim_idx;
    logic             in_cfg, in_lim, ctrl_hit, framing;
    logic             cfg_we, lim_we, ack_cond;
    logic [7:0]       cfg_rdata, lim_rdata, rd_byte;

    // Pointer classification within the selected space
    assign cfg_off  = ptr_q - CFG_LO;
    assign lim_off  = ptr_q - LIM_LO;
    assign lim_idx  = lim_off[LIM_IW-1:0];
    assign in_cfg   = cfg_sel_q  && (cfg_off < PTR_W'(CFG_DEPTH));
    assign in_lim   = !cfg_sel_q && (lim_off < PTR_W'(LIM_SPAN));
    assign lim_next = (lim_off == PTR_W'(LIM_SPAN - 1)) ? LIM_LO : ptr_q + 1'b1;
    assign framing  = bus_start || bus_stop;

    assign ctrl_hit = (rx_byte[3:1] == strap_addr) &&
                      (rx_byte[7:4] == DT_CFG || rx_byte[7:4] == DT_ADC);

    // Next-state and pointer logic
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        cfg_sel_d = cfg_sel_q;
        cfg_we    = 1'b0;
        lim_we    = 1'b0;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_CTRL;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_CTRL: begin
                    if (ctrl_hit) begin
                        cfg_sel_d = (rx_byte[7:4] == DT_CFG);
                        state_d   = rx_byte[0] ? ST_RDATA : ST_ADDR;
                    end else begin
                        state_d   = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    ptr_d   = rx_byte;
                    state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (cfg_sel_q) begin
                        cfg_we  = in_cfg;
                        state_d = ST_WDONE;
                    end else if (in_lim) begin
                        lim_we  = 1'b1;
                        ptr_d   = lim_next;
                    end
                end
                default: ;
            endcase
        end else if (tx_req && state_q == ST_RDATA && in_lim) begin
            ptr_d = lim_next;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            cfg_sel_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ptr_q     <= ptr_d;
            cfg_sel_q <= cfg_sel_d;
        end
    end

    // Output decisions
    always_comb begin
        unique case (state_q)
            ST_CTRL:                     ack_cond = ctrl_hit;
            ST_ADDR, ST_WDATA, ST_WDONE: ack_cond = 1'b1;
            default:                     ack_cond = 1'b0;
        endcase
    end

    assign rd_byte = in_cfg ? cfg_rdata : (in_lim ? lim_rdata : 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= 8'hFF;
        end else begin
            ack_valid <= rx_valid;
            ack_ok    <= rx_valid && !framing && ack_cond;
            tx_valid  <= tx_req;
            tx_byte   <= (tx_req && !framing && state_q == ST_RDATA) ? rd_byte : 8'hFF;
        end
    end

    twi_cfg_bank #(.DEPTH(CFG_DEPTH)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (cfg_off[CFG_AW-1:0]),
        .wdata (rx_byte),
        .rdata (cfg_rdata)
    );

    twi_lim_bank #(.COUNT(LIM_COUNT), .BITS(LIM_BITS)) u_lim (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (lim_we),
        .sel      (lim_idx[LIM_IW-1:1]),
        .low_byte (lim_idx[0]),
        .wdata    (rx_byte),
        .rdata    (lim_rdata),
        .lim_flat (lim_flat)
    );

endmodule

// File: rtl/twi_reg_decoder_chk.sv
module twi_reg_decoder_chk
    import twi_dec_pkg::*;
#(
    parameter logic [7:0] LIM_FIRST = 8'hF0,
    parameter logic [7:0] LIM_LAST  = 8'hFF
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] strap_addr,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       tx_req,
    input logic       ack_valid,
    input logic       ack_ok,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input dec_state_e state_q,
    input logic [7:0] ptr_q,
    input logic       cfg_sel_q
);

    logic quiet;
    assign quiet = !bus_start && !bus_stop;

    AST_ACK_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ack_valid); // R2

    AST_TX_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid); // R2

    AST_BAD_CTRL_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL && rx_valid && quiet && rx_byte[3:1] != strap_addr)
        |=> (!ack_ok && state_q == ST_IDLE)); // R1

    AST_IDLE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && quiet) |=> (ack_valid && !ack_ok)); // R1

    AST_CFG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA && cfg_sel_q && rx_valid && quiet)
        |=> state_q == ST_WDONE); // R4

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA && !cfg_sel_q && rx_valid && quiet && ptr_q == LIM_LAST)
        |=> ptr_q == LIM_FIRST); // R6

    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state_q == ST_IDLE && ptr_q == $past(ptr_q))); // R9

    AST_TX_IDLE_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && state_q != ST_RDATA) |=> tx_byte == 8'hFF); // R10

endmodule

bind twi_reg_decoder twi_reg_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_addr (strap_addr),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .tx_req     (tx_req),
    .ack_valid  (ack_valid),
    .ack_ok     (ack_ok),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .state_q    (state_q),
    .ptr_q      (ptr_q),
    .cfg_sel_q  (cfg_sel_q)
);

// File: tb/test_twi_reg_decoder.sv
`timescale 1ns/1ps
module test_twi_reg_decoder;

    localparam logic [2:0] STRAP = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        ack_valid, ack_ok, tx_valid;
    logic [7:0]  tx_byte;
    logic [79:0] lim_flat;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    twi_reg_decoder i_twi_reg_decoder (
        .clk(clk), .rst_n(rst_n), .strap_addr(STRAP),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .ack_valid(ack_valid), .ack_ok(ack_ok),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .lim_flat(lim_flat)
    );

    // Behavioural reference model
    localparam int M_IDLE = 0, M_CTRL = 1, M_ADDR = 2, M_WR = 3, M_DONE = 4, M_RD = 5;
    int         m_state = M_IDLE;
    bit         m_cfg   = 0;
    int         m_ptr   = 0;
    logic [7:0] m_cfgmem [32];
    logic [9:0] m_lim    [8];

    logic        e_ackv = 0, e_ack = 0, e_txv = 0;
    logic [7:0]  e_tx = 8'hFF;
    string       e_tag = "R11";

    function automatic logic [79:0] model_flat();
        logic [79:0] f;
        for (int k = 0; k < 8; k++) f[k*10 +: 10] = m_lim[k];
        return f;
    endfunction

    task automatic check(string tag, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(e_tag, "ack_valid", 80'(ack_valid), 80'(e_ackv));
        check(e_tag, "ack_ok",    80'(ack_ok),    80'(e_ack));
        check(e_tag, "tx_valid",  80'(tx_valid),  80'(e_txv));
        check(e_tag, "tx_byte",   80'(tx_byte),   80'(e_tx));
        check(e_tag, "lim_flat",  lim_flat,       model_flat());
    endtask

    function automatic int wrap_next(int p);
        return (p == 8'hFF) ? 8'hF0 : p + 1;
    endfunction

    task automatic model_step(bit st, bit sp, bit rv, logic [7:0] b, bit tr);
        int dt;
        e_ackv = rv; e_ack = 0; e_txv = tr; e_tx = 8'hFF;
        if (sp) m_state = M_IDLE;
        else if (st) m_state = M_CTRL;
        else if (rv) begin
            case (m_state)
                M_CTRL: begin
                    dt = int'(b[7:4]);
                    if (b[3:1] == STRAP && (dt == 4'hB || dt == 4'h9)) begin
                        e_ack = 1; m_cfg = (dt == 4'hB);
                        m_state = b[0] ? M_RD : M_ADDR;
                    end else m_state = M_IDLE;
                end
                M_ADDR: begin e_ack = 1; m_ptr = int'(b); m_state = M_WR; end
                M_WR: begin
                    e_ack = 1;
                    if (m_cfg) begin
                        if (m_ptr >= 8'h80 && m_ptr <= 8'h9F) m_cfgmem[m_ptr - 8'h80] = b;
                        m_state = M_DONE;
                    end else if (m_ptr >= 8'hF0) begin
                        if (m_ptr % 2 == 0) m_lim[(m_ptr - 8'hF0) / 2][9:8] = b[1:0];
                        else                m_lim[(m_ptr - 8'hF0) / 2][7:0] = b;
                        m_ptr = wrap_next(m_ptr);
                    end
                end
                M_DONE: e_ack = 1;
                default: e_ack = 0;
            endcase
        end else if (tr && m_state == M_RD) begin
            if (m_cfg && m_ptr >= 8'h80 && m_ptr <= 8'h9F) e_tx = m_cfgmem[m_ptr - 8'h80];
            else if (!m_cfg && m_ptr >= 8'hF0) begin
                if (m_ptr % 2 == 0) e_tx = {6'b0, m_lim[(m_ptr - 8'hF0) / 2][9:8]};
                else                e_tx = m_lim[(m_ptr - 8'hF0) / 2][7:0];
                m_ptr = wrap_next(m_ptr);
            end else e_tx = 8'h00;
        end
    endtask

    // One clock: compare previous cycle's expectations, then drive this cycle
    task automatic cyc(bit st, bit sp, bit rv, logic [7:0] b, bit tr, string tag);
        @(negedge clk);
        compare_outputs();
        bus_start = st; bus_stop = sp; rx_valid = rv; rx_byte = b; tx_req = tr;
        model_step(st, sp, rv, b, tr);
        e_tag = tag;
    endtask

    task automatic s_start(string tag);            cyc(1, 0, 0, 8'h00, 0, tag); endtask
    task automatic s_stop(string tag);             cyc(0, 1, 0, 8'h00, 0, tag); endtask
    task automatic s_byte(logic [7:0] b, string tag); cyc(0, 0, 1, b, 0, tag);   endtask
    task automatic s_read(string tag);             cyc(0, 0, 0, 8'h00, 1, tag); endtask
    task automatic s_idle(string tag);             cyc(0, 0, 0, 8'h00, 0, tag); endtask

    // Control bytes for strap 101: type | addr | rw
    localparam logic [7:0] CFG_W = 8'hBA, CFG_R = 8'hBB, ADC_W = 8'h9A, ADC_R = 8'h9B;

    initial begin
        for (int i = 0; i < 32; i++) m_cfgmem[i] = 8'h00;
        for (int k = 0; k < 8; k++)  m_lim[k] = 10'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        s_idle("R11");
        s_idle("R11");

        // R10: read request with no transaction
        s_read("R10");
        s_idle("R10");

        // R3/R4: configuration write, second data byte discarded
        s_start("R3"); s_byte(CFG_W, "R1"); s_byte(8'h85, "R3");
        s_byte(8'h3C, "R4"); s_byte(8'h77, "R4"); s_stop("R4");
        // R7: random read from configuration space, pointer holds
        s_start("R7"); s_byte(CFG_W, "R7"); s_byte(8'h85, "R7");
        s_start("R7"); s_byte(CFG_R, "R7"); s_read("R7"); s_read("R7");
        s_byte(8'h11, "R10"); s_stop("R7");
        // neighbour byte untouched by the discarded write
        s_start("R4"); s_byte(CFG_W, "R4"); s_byte(8'h86, "R4");
        s_start("R4"); s_byte(CFG_R, "R4"); s_read("R4"); s_stop("R4");

        // R5/R6: page write of limits 0 and 1
        s_start("R5"); s_byte(ADC_W, "R5"); s_byte(8'hF0, "R5");
        s_byte(8'hFF, "R5"); s_byte(8'h12, "R5");
        s_byte(8'h01, "R6"); s_byte(8'hAB, "R6"); s_stop("R6");
        // R6: wrap from 0xFF to 0xF0
        s_start("R6"); s_byte(ADC_W, "R6"); s_byte(8'hFE, "R6");
        s_byte(8'h03, "R6"); s_byte(8'h44, "R6"); s_byte(8'h01, "R6");
        s_byte(8'h5A, "R6"); s_stop("R6");
        // R7: limit page read with wrap
        s_start("R7"); s_byte(ADC_W, "R7"); s_byte(8'hFE, "R7");
        s_start("R7"); s_byte(ADC_R, "R7");
        s_read("R7"); s_read("R7"); s_read("R7"); s_read("R7"); s_stop("R7");

        // R1: wrong bus address, then more bytes stay unacknowledged
        s_start("R1"); s_byte(8'h98, "R1"); s_byte(8'hF0, "R1"); s_byte(8'h55, "R1"); s_stop("R1");
        // R1: wrong device type
        s_start("R1"); s_byte(8'hAA, "R1"); s_byte(8'hF2, "R1"); s_stop("R1");
        s_start("R1"); s_byte(8'h8B, "R1"); s_read("R1"); s_stop("R1");

        // R8: out-of-range write and read in converter space
        s_start("R8"); s_byte(ADC_W, "R8"); s_byte(8'h10, "R8");
        s_byte(8'h55, "R8"); s_byte(8'h66, "R8"); s_stop("R8");
        s_start("R8"); s_byte(ADC_R, "R8"); s_read("R8"); s_read("R8"); s_stop("R8");
        // R8: configuration space pointed at limit block
        s_start("R8"); s_byte(CFG_W, "R8"); s_byte(8'hF0, "R8"); s_byte(8'h66, "R8"); s_stop("R8");
        s_start("R8"); s_byte(CFG_R, "R8"); s_read("R8"); s_stop("R8");
        // R9: pointer survives stop; read with no pointer byte
        s_start("R9"); s_byte(ADC_R, "R9"); s_read("R9"); s_read("R9"); s_stop("R9");
        s_idle("R9");
        // R2: back-to-back reads
        s_start("R2"); s_byte(ADC_W, "R2"); s_byte(8'hF3, "R2");
        s_start("R2"); s_byte(ADC_R, "R2"); s_read("R2"); s_read("R2"); s_read("R2");
        s_stop("R2");
        s_idle("R2");
        s_idle("R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule